// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block keeps the register state of a single-channel digital potentiometer. An upstream serial-bus slave has already decoded each transfer into a register address, a write strobe with a data byte, and a read strobe. The block turns these into updates of a 7-bit wiper code, which is driven straight to the resistor switch array. It also handles a one-byte initial-value word that survives reset, and a mode register that chooses which of the two words address 0 reaches.

After reset, a sequencer sets the wiper to mid-scale. It holds it there for a settling window and then copies the stored initial value into the wiper. Only after that does it accept bus accesses.

Writes to the initial-value word take a parameterised number of cycles. During that time a busy flag is high and address 0 refuses further writes.

Top module: `dpot_regctl`

## Requirements
- R1: The wiper code is 7 bits wide, where 00h is the tap nearest the low terminal and 7Fh the tap nearest the high terminal. From reset until the power-up load, the wiper code is 40h.
- R2: `ready` rises exactly MID_CYCLES+2 clock edges after `rst` is released. In that same edge the wiper takes the low 7 bits of the committed initial value.
- R3: Reads of addresses 1 and 3 return 00h. Writes to them change nothing.
- R4: The mode register (address 2) resets to 00h. In mode 00h, a read of address 0 returns the committed initial value, and a write to address 0 loads the wiper and starts a store of the same value into the initial-value word.
- R5: In mode 80h, a read of address 0 returns the wiper, and a write to address 0 updates only the wiper.
- R6: A write to address 2 takes effect only with the value 00h or 80h. Any other value leaves the mode unchanged. A read of address 2 returns the mode (00h or 80h).
- R7: On the first power-up the initial value is 40h. The initial value is kept across `rst`.
- R8: A store raises `nv_busy` for NV_WR_CYCLES cycles, starting the cycle after the write. The new value is committed when busy falls. While busy, writes to address 0 are ignored, and reads in mode 00h return the previous committed value.
- R9: Data bit 7 is dropped on writes to address 0. Reads of the wiper or the initial value return bit 7 as 0.
- R10: `rd_valid` is high for exactly the cycle after an accepted read strobe, with `rd_data` valid in that cycle.
- R11: Before `ready`, read strobes produce no `rd_valid` and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Decoded register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data byte |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid |
| wiper_code | output | CODE_W | Wiper tap select |
| nv_busy | output | 1 | Initial-value store in progress |
| ready | output | 1 | Power-up finished, bus accepted |

## Verification
Read data, `rd_valid`, wiper updates and the rise of `nv_busy` are all due one edge after the strobe. The bench drives strobes on the falling edge and samples on the next falling edge, so every check lands one full register stage after its stimulus.

The commit of the initial value and the fall of `nv_busy` come NV_WR_CYCLES edges after that. `ready` and the power-up load come MID_CYCLES+2 edges after reset release. A cycle-stepped bench model advances its own busy countdown and power-up count by one per clock and compares against the ports on every cycle.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    PU_RESET = 2'd0,
    PU_MID   = 2'd1,
    PU_LOAD  = 2'd2,
    PU_READY = 2'd3
  } pu_state_e;

  // Register indices on the decoded bus
  localparam int ADR_CODE_IDX = 0;
  localparam int ADR_MODE_IDX = 2;

  // Mid-scale wiper code applied while power comes up
  localparam int MID_CODE_VAL = 64;
endpackage

// File: rtl/dpot_pwrup_seq.sv
module dpot_pwrup_seq
  import dpot_pkg::*;
#(
  parameter int MID_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic load_o,
  output logic ready_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(MID_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(MID_CYCLES - 1);

  pu_state_e       state_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PU_RESET;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PU_RESET: begin
          state_q <= PU_MID;
          cnt_q   <= '0;
        end
        PU_MID: begin
          if (cnt_q == LAST) state_q <= PU_LOAD;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        PU_LOAD:  state_q <= PU_READY;
        default:  state_q <= PU_READY;
      endcase
    end
  end

  assign load_o  = (state_q == PU_LOAD);
  assign ready_o = (state_q == PU_READY);

  // R2: ready is entered only through the load step, and then stays
  a_r2_ready_via_load: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(load_o));
  a_r2_ready_holds: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);
endmodule

// File: rtl/dpot_nv_store.sv
module dpot_nv_store #(
  parameter int          CODE_W       = 7,
  parameter int          NV_WR_CYCLES = 8,
  parameter logic [6:0]  INIT_VALUE   = 7'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] value_o,
  output logic              busy_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BW = $clog2(NV_WR_CYCLES + 1);

  // Non-volatile word: power-on value only, untouched by rst
  logic [CODE_W-1:0] ivr_q = CODE_W'(INIT_VALUE);
  logic [CODE_W-1:0] pend_q;
  logic [BW-1:0]     left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else if (start_i) begin
      left_q <= BW'(NV_WR_CYCLES);
    end
  end

  always_ff @(posedge clk) begin
    if (start_i && left_q == '0) pend_q <= data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst && left_q == BW'(1)) ivr_q <= pend_q;
  end

  assign value_o = ivr_q;
  assign busy_o  = (left_q != '0);

  // R8: the committed word changes only as busy drops
  a_r8_commit_at_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(value_o) |-> ($past(busy_o) && !busy_o));
  // R8: an accepted start raises busy on the next edge
  a_r8_busy_starts: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/dpot_reg_access.sv
module dpot_reg_access
  import dpot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 7,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] nv_value_i,
  input  logic              nv_busy_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic              nv_start_o,
  output logic [CODE_W-1:0] nv_data_o,
  output logic [CODE_W-1:0] wiper_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [ADDR_W-1:0] A_CODE   = ADDR_W'(ADR_CODE_IDX);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADR_MODE_IDX);
  localparam logic [CODE_W-1:0] MID      = CODE_W'(MID_CODE_VAL);
  localparam logic [DATA_W-1:0] MODE_VOL = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int                PAD_W    = DATA_W - CODE_W;

  logic              wiper_q;
  logic [CODE_W-1:0] code_q;
  logic              vol_only_q;
  logic [DATA_W-1:0] rd_q;
  logic              rv_q;
  logic              hit_code, hit_mode, mode_ok, wr_code, wr_mode, rd_ok;
  logic [DATA_W-1:0] rd_mux;

  assign hit_code = (bus_addr == A_CODE);
  assign hit_mode = (bus_addr == A_MODE);
  assign mode_ok  = (bus_wdata == '0) || (bus_wdata == MODE_VOL);
  assign wr_code  = ready_i && bus_wr && hit_code && !nv_busy_i;
  assign wr_mode  = ready_i && bus_wr && hit_mode && mode_ok;
  assign rd_ok    = ready_i && bus_rd;

  assign nv_start_o = wr_code && !vol_only_q;
  assign nv_data_o  = bus_wdata[CODE_W-1:0];

  always_comb begin
    rd_mux = '0;
    if (hit_code) begin
      rd_mux = vol_only_q ? {{PAD_W{1'b0}}, code_q} : {{PAD_W{1'b0}}, nv_value_i};
    end else if (hit_mode) begin
      rd_mux = {vol_only_q, {(DATA_W-1){1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q     <= MID;
      vol_only_q <= 1'b0;
      rv_q       <= 1'b0;
      rd_q       <= '0;
    end else begin
      if (load_i)       code_q <= nv_value_i;
      else if (wr_code) code_q <= bus_wdata[CODE_W-1:0];
      if (wr_mode) vol_only_q <= bus_wdata[DATA_W-1];
      rv_q <= rd_ok;
      if (rd_ok) rd_q <= rd_mux;
    end
  end

  assign wiper_q    = 1'b0;
  assign wiper_o    = code_q;
  assign rd_data_o  = rd_q;
  assign rd_valid_o = rv_q;

  // R11: no wiper change and no read response before ready
  a_r11_quiet_before_ready: assert property (@(posedge clk) disable iff (rst)
    (!ready_i && !load_i) |=> ($stable(code_q) && !rd_valid_o));
  // R8: writes to the code address during busy leave the wiper alone
  a_r8_reject_busy: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_code && nv_busy_i && !load_i) |=> $stable(code_q));
  // R6: illegal mode values are dropped
  a_r6_mode_illegal: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_mode && !mode_ok) |=> $stable(vol_only_q));
  // R10: a response follows one edge after an accepted read strobe
  a_r10_rd_cadence: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(bus_rd && ready_i));
endmodule

// File: rtl/dpot_regctl.sv
module dpot_regctl #(
  parameter int         DATA_W       = 8,
  parameter int         CODE_W       = 7,
  parameter int         ADDR_W       = 2,
  parameter int         MID_CYCLES   = 16,
  parameter int         NV_WR_CYCLES = 8,
  parameter logic [6:0] IVR_DEFAULT  = 7'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [CODE_W-1:0] wiper_code,
  output logic              nv_busy,
  output logic              ready
);
  timeunit 1ns;
  timeprecision 1ps;

  logic              load_w, ready_w, start_w, busy_w;
  logic [CODE_W-1:0] nv_val_w, nv_dat_w;

  dpot_pwrup_seq #(.MID_CYCLES(MID_CYCLES)) seq_i (
    .clk(clk), .rst(rst), .load_o(load_w), .ready_o(ready_w)
  );

  dpot_nv_store #(
    .CODE_W(CODE_W), .NV_WR_CYCLES(NV_WR_CYCLES), .INIT_VALUE(IVR_DEFAULT)
  ) nv_i (
    .clk(clk), .rst(rst), .start_i(start_w), .data_i(nv_dat_w),
    .value_o(nv_val_w), .busy_o(busy_w)
  );

  dpot_reg_access #(.DATA_W(DATA_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) acc_i (
    .clk(clk), .rst(rst), .ready_i(ready_w), .load_i(load_w),
    .nv_value_i(nv_val_w), .nv_busy_i(busy_w),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .nv_start_o(start_w), .nv_data_o(nv_dat_w), .wiper_o(wiper_code),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  assign nv_busy = busy_w;
  assign ready   = ready_w;

  // R2: the wiper moves only in the load step or on a ready-cycle write
  a_r2_wiper_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(wiper_code) |-> ($past(load_w) || $past(ready_w && bus_wr)));
endmodule

// File: tb/dpot_regctl_tb_top.sv
module dpot_regctl_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MID = 16;
  localparam int NVW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       rd_valid, nv_busy, ready;
  logic [6:0] wiper;

  always #2 clk = ~clk;

  dpot_regctl #(.MID_CYCLES(MID), .NV_WR_CYCLES(NVW)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .rd_data(rd_data), .rd_valid(rd_valid), .wiper_code(wiper),
    .nv_busy(nv_busy), .ready(ready)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench model of the requirements
  bit [6:0] m_wiper = 7'h40, m_ivr = 7'h40, m_pend = '0;
  bit       m_vol = 0, m_rdy = 0, exp_rv = 0;
  int       m_left = 0;
  bit [7:0] exp_rd = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] read_model(input bit [1:0] a);
    if (a == 2'd0) return m_vol ? {1'b0, m_wiper} : {1'b0, m_ivr};
    if (a == 2'd2) return {m_vol, 7'b0};
    return 8'h00;
  endfunction

  function automatic void step();
    bit start = 0;
    exp_rv = 0;
    if (rst) begin
      m_wiper = 7'h40; m_vol = 0; m_left = 0; m_rdy = 0;
      return;
    end
    if (m_rdy) begin
      if (rd) begin exp_rv = 1; exp_rd = read_model(addr); end
      if (wr && addr == 2'd0 && m_left == 0) begin
        m_wiper = wdata[6:0];
        start = !m_vol;
      end
      if (wr && addr == 2'd2 && (wdata == 8'h00 || wdata == 8'h80)) m_vol = wdata[7];
    end
    if (m_left != 0) begin
      if (m_left == 1) m_ivr = m_pend;
      m_left--;
    end else if (start) begin
      m_left = NVW; m_pend = wdata[6:0];
    end
  endfunction

  task automatic cyc();
    @(posedge clk);
    step();
    @(negedge clk);
    if (m_rdy) begin
      chk(rd_valid == exp_rv, "R10 rd_valid", rd_valid, exp_rv);
      if (exp_rv) chk(rd_data == exp_rd, "R3 R4 R5 read data", rd_data, exp_rd);
      chk(wiper == m_wiper, "R4 R5 wiper", wiper, m_wiper);
      chk(nv_busy == (m_left != 0), "R8 busy", nv_busy, m_left != 0);
    end
  endtask

  task automatic acc(input bit [1:0] a, input bit w, input bit r, input bit [7:0] d);
    addr = a; wr = w; rd = r; wdata = d;
    cyc();
    wr = 0; rd = 0;
  endtask

  task automatic power_up(input bit poke);
    rst = 1; wr = 0; rd = 0;
    cyc(); cyc();
    chk(ready == 0, "R2 reset ready", ready, 0);
    chk(wiper == 7'h40, "R1 reset wiper", wiper, 7'h40);
    chk(rd_valid == 0, "R10 reset rd_valid", rd_valid, 0);
    rst = 0;
    for (int i = 1; i <= MID + 2; i++) begin
      if (poke && i <= 2) begin addr = 0; wr = 1; rd = 1; wdata = 8'h7F; end
      cyc();
      wr = 0; rd = 0;
      if (poke && i <= 2) chk(rd_valid == 0, "R11 read before ready", rd_valid, 0);
      if (i <= MID + 1) begin
        chk(wiper == 7'h40, "R1 mid-scale", wiper, 7'h40);
        if (i == MID + 1) chk(ready == 0, "R2 ready early", ready, 0);
      end else begin
        chk(ready == 1, "R2 ready on time", ready, 1);
        m_rdy = 1; m_wiper = m_ivr;
        chk(wiper == m_ivr, "R2 R7 load initial", wiper, m_ivr);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    power_up(0);
    chk(wiper == 7'h40, "R7 factory wiper", wiper, 7'h40);
    acc(2, 0, 1, 0);   chk(rd_data == 8'h00, "R4 mode reset", rd_data, 0);
    acc(0, 0, 1, 0);   chk(rd_data == 8'h40, "R7 factory value", rd_data, 8'h40);
    acc(0, 1, 0, 8'hA5);
    chk(wiper == 7'h25, "R9 bit7 dropped", wiper, 7'h25);
    chk(nv_busy == 1, "R8 busy raised", nv_busy, 1);
    acc(0, 0, 1, 0);   chk(rd_data == 8'h40, "R8 old value while busy", rd_data, 8'h40);
    acc(0, 1, 0, 8'h11); chk(wiper == 7'h25, "R8 write rejected", wiper, 7'h25);
    repeat (NVW - 2) cyc();
    chk(nv_busy == 0, "R8 busy length", nv_busy, 0);
    acc(0, 0, 1, 0);   chk(rd_data == 8'h25, "R4 R9 committed", rd_data, 8'h25);
    cyc();             chk(rd_valid == 0, "R10 single pulse", rd_valid, 0);
    acc(2, 1, 0, 8'h33); acc(2, 0, 1, 0);
    chk(rd_data == 8'h00, "R6 illegal mode", rd_data, 0);
    acc(2, 1, 0, 8'h80); acc(2, 0, 1, 0);
    chk(rd_data == 8'h80, "R6 mode readback", rd_data, 8'h80);
    acc(0, 1, 0, 8'h0A);
    chk(wiper == 7'h0A, "R5 wiper only", wiper, 7'h0A);
    chk(nv_busy == 0, "R5 no store", nv_busy, 0);
    acc(0, 0, 1, 0);   chk(rd_data == 8'h0A, "R5 reads wiper", rd_data, 8'h0A);
    acc(2, 1, 0, 8'h00); acc(0, 0, 1, 0);
    chk(rd_data == 8'h25, "R5 initial untouched", rd_data, 8'h25);
    acc(1, 1, 0, 8'h77); acc(1, 0, 1, 0);
    chk(rd_data == 8'h00, "R3 address 1", rd_data, 0);
    acc(3, 1, 0, 8'h80); acc(3, 0, 1, 0);
    chk(rd_data == 8'h00, "R3 address 3", rd_data, 0);
    acc(2, 0, 1, 0);   chk(rd_data == 8'h00, "R3 mode unchanged", rd_data, 0);
    power_up(1);
    chk(wiper == 7'h25, "R7 kept over reset", wiper, 7'h25);
    for (int i = 0; i < 800; i++) begin
      bit [1:0] a = 2'($urandom % 4);
      bit [7:0] d = 8'($urandom);
      int k = $urandom % 4;
      if (a == 2 && k != 0) d = (k == 1) ? 8'h00 : 8'h80;
      acc(a, ($urandom % 3) == 0, ($urandom % 2) == 0, d);
      if ($urandom % 4 == 0) cyc();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule